// File: doc/BRIEF.md
# SMBus Block Process-Call Master Sequencer

This block sits between firmware and a bit-level SMBus/PMBus bus engine. It works at byte level. It runs two complete master transactions. The first is a combined block write followed by a block read, with an optional packet error code. The second is the alert response, a single receive-byte from the alert address. The bus engine performs one primitive per request: start, repeated start, stop, byte write, byte read, or ack/nack bit. The sequencer issues each primitive and waits for the engine to report it done. It then decides the next primitive from the slave's answers.

Firmware first fills a small write-data buffer. It then writes the configuration with a single strobe: slave address, command byte, write count, process-call enable and PEC enable. The block reports the following:
- a busy level;
- a one-cycle end-of-message pulse;
- three sticky error flags, for a slave NACK, a bad read count and a PEC mismatch;
- the received count and bytes, through an indexed read port.

A rising edge on the alert input raises a one-cycle interrupt.

Top module: `smbus_pcall_master`

## Requirements
- R1: A `cfgWrite` pulse while idle starts a transaction only when `cfgProcCall` is 1 or `cfgAddr` equals 7'h0C. Otherwise nothing happens. A started transaction first issues a START primitive. `busy` stays high from that cycle until the STOP primitive is reported done.
- R2: The process call writes these bytes in order: {addr,1'b0}, then the command byte, then the count N (0 to 32), then write-buffer entries 0 to N-1. Every byte is a WRITE primitive.
- R3: After the last write byte the block issues a RESTART with no STOP in between. It then writes {addr,1'b1}.
- R4: The block then reads the count byte and ACKs it. It reads that many data bytes and ACKs every data byte except the final one. Afterwards `rxCount` holds the count and `rxData` at index i holds data byte i.
- R5: Without PEC, the final data byte is NACKed and the STOP follows directly.
- R6: With PEC, one extra byte is read after the data and NACKed, then STOP follows. The PEC is a CRC-8 with polynomial 0x07 and initial value 0. It runs over every byte on the bus: both address bytes, the command, both counts and all data. `pecErr` is set when the received PEC differs from this CRC.
- R7: The alert response runs START, WRITE 8'h19, READ, NACK and STOP, with PEC off whatever `cfgPecEn` says. The returned byte appears at `rxData` index 0, and `rxCount` reads 1.
- R8: When the slave fails to ACK any written byte, the block stops writing and issues STOP. It also sets `nackErr` and still pulses `eomIrq`.
- R9: A read count of 0, or of more than 32, is NACKed and followed by STOP. The block sets `cntErr` and leaves `rxCount` at 0.
- R10: `eomIrq` is a one-cycle pulse. It comes in the cycle in which `busy` falls, at the end of every transaction. The error flags are cleared when the next transaction starts.
- R11: While busy, `cfgWrite` and `wdWrite` have no effect.
- R12: A rising edge on `alertIn` gives a one-cycle `alertIrq` pulse in the following cycle.
- R13: Each primitive is a one-cycle `engCmdValid` pulse. The next primitive is issued only after `engDone`. Command codes: 1 START, 2 RESTART, 3 STOP, 4 WRITE, 5 READ, 6 ACK. `engAckOut` = 1 means ACK. `engAckIn` = 1 means the slave acked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrite | input | 1 | Configuration write strobe |
| cfgAddr | input | 7 | Slave address |
| cfgCommand | input | 8 | Command byte |
| cfgCount | input | 6 | Write byte count N |
| cfgProcCall | input | 1 | Process-call enable |
| cfgPecEn | input | 1 | PEC enable |
| wdWrite | input | 1 | Write-buffer write strobe |
| wdIndex | input | 5 | Write-buffer index |
| wdData | input | 8 | Write-buffer data |
| rxIndex | input | 5 | Receive-buffer read index |
| rxData | output | 8 | Receive-buffer data at rxIndex |
| rxCount | output | 6 | Received byte count |
| busy | output | 1 | Transaction in progress |
| eomIrq | output | 1 | End-of-message pulse |
| nackErr | output | 1 | Slave NACK error flag |
| pecErr | output | 1 | PEC mismatch flag |
| cntErr | output | 1 | Read count error flag |
| alertIn | input | 1 | Alert line from the slaves, active high |
| alertIrq | output | 1 | Alert interrupt pulse |
| engCmdValid | output | 1 | Primitive request pulse |
| engCmd | output | 3 | Primitive code |
| engTxByte | output | 8 | Byte to write |
| engAckOut | output | 1 | Ack bit to send |
| engDone | input | 1 | Engine finished the primitive |
| engAckIn | input | 1 | Slave ack for a written byte |
| engRxByte | input | 8 | Byte read by the engine |

## Verification
The hardest cases are the abort paths: a NACK on one particular written byte, an out-of-range read count, and a wrong PEC. Each needs a slave that answers one specific primitive deliberately wrong. The bench's engine model therefore counts WRITE primitives and NACKs a chosen one. It also serves read bytes from a queue whose count and PEC bytes are planted on purpose. A configuration strobe and a buffer write are injected in the middle of a running transaction. A following transaction then reuses the untouched buffer, which exposes any write that should have been ignored.

// File: rtl/pcm_pkg.sv
package pcm_pkg;

  localparam logic [6:0] ALERT_ADDR = 7'h0C;

  typedef enum logic [2:0] {
    ENG_NONE    = 3'd0,
    ENG_START   = 3'd1,
    ENG_RESTART = 3'd2,
    ENG_STOP    = 3'd3,
    ENG_WRITE   = 3'd4,
    ENG_READ    = 3'd5,
    ENG_ACK     = 3'd6
  } engCmd_e;

  typedef enum logic [2:0] {
    TX_ADDRW, TX_ADDRR, TX_CMD, TX_CNT, TX_DATA
  } txSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic   loadCfg;
    logic   crcTx;
    logic   crcRx;
    logic   incIdx;
    logic   clrIdx;
    logic   storeCnt;
    logic   storeData;
    logic   setNack;
    logic   setCnt;
    logic   setPec;
    txSel_e txSel;
  } strobe_t;

  // CRC-8, polynomial x^8+x^2+x+1, one byte per call
  function automatic logic [7:0] crc8Step(input logic [7:0] crc, input logic [7:0] din);
    logic [7:0] c;
    c = crc ^ din;
    for (int i = 0; i < 8; i++) begin
      c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/pcm_datapath.sv
module pcm_datapath
  import pcm_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic             busy,
  input  logic [6:0]       cfgAddr,
  input  logic [7:0]       cfgCommand,
  input  logic [CNT_W-1:0] cfgCount,
  input  logic             cfgPecEn,
  input  logic             wdWrite,
  input  logic [IDX_W-1:0] wdIndex,
  input  logic [7:0]       wdData,
  input  logic [IDX_W-1:0] rxIndex,
  input  logic [7:0]       engRxByte,
  input  logic             alertIn,
  output logic [7:0]       txByte,
  output logic [7:0]       rxData,
  output logic [CNT_W-1:0] rxCount,
  output logic             nackErr,
  output logic             pecErr,
  output logic             cntErr,
  output logic             alertIrq,
  output logic             alertMode,
  output logic             pecOn,
  output logic             wrZero,
  output logic             wrLast,
  output logic             rxLast,
  output logic             cntBad,
  output logic             crcZero
);

  logic [7:0]       wrBuf [DEPTH];
  logic [7:0]       rxBuf [DEPTH];
  logic [6:0]       addrR;
  logic [7:0]       cmdR;
  logic [CNT_W-1:0] wrCnt;
  logic [CNT_W-1:0] idx;
  logic [7:0]       crc;
  logic             alertQ;

  always_comb begin
    unique case (stb.txSel)
      TX_ADDRW: txByte = {addrR, 1'b0};
      TX_ADDRR: txByte = {addrR, 1'b1};
      TX_CMD:   txByte = cmdR;
      TX_CNT:   txByte = 8'(wrCnt);
      default:  txByte = wrBuf[idx[IDX_W-1:0]];
    endcase
  end

  assign rxData  = rxBuf[rxIndex];
  assign wrZero  = (wrCnt == '0);
  assign wrLast  = (CNT_W'(idx + 1'b1) == wrCnt);
  assign rxLast  = (CNT_W'(idx + 1'b1) == rxCount);
  assign cntBad  = (engRxByte == 8'd0) || (engRxByte > 8'(DEPTH));
  assign crcZero = (crc == 8'd0);

  always_ff @(posedge clk) begin
    if (wdWrite && !busy) wrBuf[wdIndex] <= wdData;
    if (stb.storeData) rxBuf[idx[IDX_W-1:0]] <= engRxByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrR <= '0; cmdR <= '0; wrCnt <= '0; idx <= '0; crc <= '0;
      rxCount <= '0; alertMode <= 1'b0; pecOn <= 1'b0;
      nackErr <= 1'b0; pecErr <= 1'b0; cntErr <= 1'b0;
      alertQ <= 1'b0; alertIrq <= 1'b0;
    end else begin
      alertQ   <= alertIn;
      alertIrq <= alertIn && !alertQ;
      if (stb.loadCfg) begin
        addrR     <= cfgAddr;
        cmdR      <= cfgCommand;
        wrCnt     <= cfgCount;
        alertMode <= (cfgAddr == ALERT_ADDR);
        pecOn     <= cfgPecEn && (cfgAddr != ALERT_ADDR);
        idx       <= '0;
        rxCount   <= '0;
        crc       <= '0;
        nackErr   <= 1'b0;
        pecErr    <= 1'b0;
        cntErr    <= 1'b0;
      end else begin
        if (stb.crcTx)      crc <= crc8Step(crc, txByte);
        else if (stb.crcRx) crc <= crc8Step(crc, engRxByte);
        if (stb.clrIdx)      idx <= '0;
        else if (stb.incIdx) idx <= idx + 1'b1;
        if (stb.storeCnt) rxCount <= CNT_W'(engRxByte);
        if (stb.storeData && alertMode) rxCount <= CNT_W'(1);
        if (stb.setNack) nackErr <= 1'b1;
        if (stb.setCnt)  cntErr  <= 1'b1;
        if (stb.setPec)  pecErr  <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/pcm_ctrl.sv
module pcm_ctrl
  import pcm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWrite,
  input  logic [6:0] cfgAddr,
  input  logic       cfgProcCall,
  input  logic       engDone,
  input  logic       engAckIn,
  input  logic       alertMode,
  input  logic       pecOn,
  input  logic       wrZero,
  input  logic       wrLast,
  input  logic       rxLast,
  input  logic       cntBad,
  input  logic       crcZero,
  output strobe_t    stb,
  output logic       engCmdValid,
  output logic [2:0] engCmd,
  output logic       engAckOut,
  output logic       busy,
  output logic       eomIrq
);

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_WADDR, S_WCMD, S_WCNT, S_WDATA, S_RSTART,
    S_RADDR, S_RCNT, S_RDATA, S_RPEC, S_ALRD, S_ACKO, S_STOP
  } state_e;

  state_e  state, nextState, afterAck, afterAckN;
  engCmd_e cmdC;
  logic    waiting, ackBit, ackBitN, chkPec, chkPecN;
  logic    issue, doneHere;

  assign issue       = (state != S_IDLE) && !waiting;
  assign doneHere    = waiting && engDone;
  assign busy        = (state != S_IDLE);
  assign engCmdValid = issue && (cmdC != ENG_NONE);
  assign engCmd      = cmdC;
  assign engAckOut   = ackBit;

  always_comb begin
    stb       = '0;
    stb.txSel = TX_DATA;
    nextState = state;
    afterAckN = afterAck;
    ackBitN   = ackBit;
    chkPecN   = chkPec;
    cmdC      = ENG_NONE;
    unique case (state)
      S_IDLE: if (cfgWrite && (cfgProcCall || cfgAddr == ALERT_ADDR)) begin
        stb.loadCfg = 1'b1;
        chkPecN     = 1'b0;
        nextState   = S_START;
      end
      S_START: begin
        cmdC = ENG_START;
        if (doneHere) nextState = alertMode ? S_RADDR : S_WADDR;
      end
      S_WADDR, S_WCMD, S_WCNT, S_WDATA, S_RADDR: begin
        cmdC      = ENG_WRITE;
        stb.crcTx = issue;
        unique case (state)
          S_WADDR: stb.txSel = TX_ADDRW;
          S_WCMD:  stb.txSel = TX_CMD;
          S_WCNT:  stb.txSel = TX_CNT;
          S_RADDR: stb.txSel = TX_ADDRR;
          default: stb.txSel = TX_DATA;
        endcase
        if (doneHere) begin
          if (!engAckIn) begin
            stb.setNack = 1'b1;
            nextState   = S_STOP;
          end else begin
            unique case (state)
              S_WADDR: nextState = S_WCMD;
              S_WCMD:  nextState = S_WCNT;
              S_WCNT:  nextState = wrZero ? S_RSTART : S_WDATA;
              S_RADDR: nextState = alertMode ? S_ALRD : S_RCNT;
              default: begin
                stb.incIdx = 1'b1;
                nextState  = wrLast ? S_RSTART : S_WDATA;
              end
            endcase
          end
        end
      end
      S_RSTART: begin
        cmdC = ENG_RESTART;
        if (doneHere) begin
          stb.clrIdx = 1'b1;
          nextState  = S_RADDR;
        end
      end
      S_RCNT, S_RDATA, S_RPEC, S_ALRD: begin
        cmdC = ENG_READ;
        if (doneHere) begin
          nextState = S_ACKO;
          stb.crcRx = (state != S_ALRD);
          ackBitN   = 1'b1;
          afterAckN = S_STOP;
          unique case (state)
            S_RCNT: begin
              if (cntBad) begin
                stb.setCnt = 1'b1;
                ackBitN    = 1'b0;
              end else begin
                stb.storeCnt = 1'b1;
                afterAckN    = S_RDATA;
              end
            end
            S_RDATA: begin
              stb.storeData = 1'b1;
              stb.incIdx    = 1'b1;
              if (!rxLast)    afterAckN = S_RDATA;
              else if (pecOn) afterAckN = S_RPEC;
              else            ackBitN   = 1'b0;
            end
            S_RPEC: begin
              ackBitN = 1'b0;
              chkPecN = 1'b1;
            end
            default: begin
              stb.storeData = 1'b1;
              ackBitN       = 1'b0;
            end
          endcase
        end
      end
      S_ACKO: begin
        cmdC = ENG_ACK;
        if (doneHere) begin
          stb.setPec = chkPec && !crcZero;
          chkPecN    = 1'b0;
          nextState  = afterAck;
        end
      end
      default: begin
        cmdC = ENG_STOP;
        if (doneHere) nextState = S_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      afterAck <= S_IDLE;
      waiting  <= 1'b0;
      ackBit   <= 1'b0;
      chkPec   <= 1'b0;
      eomIrq   <= 1'b0;
    end else begin
      state    <= nextState;
      afterAck <= afterAckN;
      ackBit   <= ackBitN;
      chkPec   <= chkPecN;
      eomIrq   <= (state == S_STOP) && doneHere;
      if (issue)         waiting <= 1'b1;
      else if (doneHere) waiting <= 1'b0;
    end
  end

endmodule

// File: rtl/smbus_pcall_master.sv
module smbus_pcall_master
  import pcm_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrite,
  input  logic [6:0]       cfgAddr,
  input  logic [7:0]       cfgCommand,
  input  logic [CNT_W-1:0] cfgCount,
  input  logic             cfgProcCall,
  input  logic             cfgPecEn,
  input  logic             wdWrite,
  input  logic [IDX_W-1:0] wdIndex,
  input  logic [7:0]       wdData,
  input  logic [IDX_W-1:0] rxIndex,
  output logic [7:0]       rxData,
  output logic [CNT_W-1:0] rxCount,
  output logic             busy,
  output logic             eomIrq,
  output logic             nackErr,
  output logic             pecErr,
  output logic             cntErr,
  input  logic             alertIn,
  output logic             alertIrq,
  output logic             engCmdValid,
  output logic [2:0]       engCmd,
  output logic [7:0]       engTxByte,
  output logic             engAckOut,
  input  logic             engDone,
  input  logic             engAckIn,
  input  logic [7:0]       engRxByte
);

  strobe_t stb;
  logic alertMode, pecOn, wrZero, wrLast, rxLast, cntBad, crcZero;

  pcm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrite(cfgWrite), .cfgAddr(cfgAddr),
    .cfgProcCall(cfgProcCall), .engDone(engDone), .engAckIn(engAckIn),
    .alertMode(alertMode), .pecOn(pecOn), .wrZero(wrZero), .wrLast(wrLast),
    .rxLast(rxLast), .cntBad(cntBad), .crcZero(crcZero), .stb(stb),
    .engCmdValid(engCmdValid), .engCmd(engCmd), .engAckOut(engAckOut),
    .busy(busy), .eomIrq(eomIrq)
  );

  pcm_datapath #(.DEPTH(DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .busy(busy), .cfgAddr(cfgAddr),
    .cfgCommand(cfgCommand), .cfgCount(cfgCount), .cfgPecEn(cfgPecEn),
    .wdWrite(wdWrite), .wdIndex(wdIndex), .wdData(wdData), .rxIndex(rxIndex),
    .engRxByte(engRxByte), .alertIn(alertIn), .txByte(engTxByte),
    .rxData(rxData), .rxCount(rxCount), .nackErr(nackErr), .pecErr(pecErr),
    .cntErr(cntErr), .alertIrq(alertIrq), .alertMode(alertMode), .pecOn(pecOn),
    .wrZero(wrZero), .wrLast(wrLast), .rxLast(rxLast), .cntBad(cntBad),
    .crcZero(crcZero)
  );

endmodule

// File: rtl/pcm_checks.sv
module pcm_checks (
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic       eomIrq,
  input logic       engCmdValid,
  input logic [2:0] engCmd,
  input logic       cntErr,
  input logic       alertIn,
  input logic       alertIrq
);

  // Transaction opens with a START primitive
  assert_start_first_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (engCmdValid && engCmd == 3'd1));

  // End pulse coincides with busy low
  assert_eom_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    eomIrq |-> !busy);

  // Primitive request is a single-cycle pulse issued only while busy
  assert_cmd_pulse_R13: assert property (@(posedge clk) disable iff (!rstN)
    engCmdValid |=> !engCmdValid);

  assert_cmd_busy_R13: assert property (@(posedge clk) disable iff (!rstN)
    engCmdValid |-> busy);

  // Count error only raised during a transaction
  assert_cnterr_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cntErr) |-> busy);

  // Alert interrupt follows a high alert line and lasts one cycle
  assert_alert_pulse_R12: assert property (@(posedge clk) disable iff (!rstN)
    alertIrq |-> ($past(alertIn) && !$past(alertIrq)));

endmodule

bind smbus_pcall_master pcm_checks u_checks (
  .clk(clk), .rstN(rstN), .busy(busy), .eomIrq(eomIrq),
  .engCmdValid(engCmdValid), .engCmd(engCmd), .cntErr(cntErr),
  .alertIn(alertIn), .alertIrq(alertIrq)
);

// File: tb/tb_smbus_pcall_master.sv
module tb_smbus_pcall_master;

  localparam int CLK_PERIOD = 10;
  localparam int E_START = 1, E_RESTART = 2, E_STOP = 3, E_WRITE = 4, E_READ = 5, E_ACK = 6;

  logic clk = 1'b0, rstN = 1'b0;
  logic cfgWrite = 0, cfgProcCall = 0, cfgPecEn = 0;
  logic [6:0] cfgAddr = '0;
  logic [7:0] cfgCommand = '0;
  logic [5:0] cfgCount = '0;
  logic wdWrite = 0;
  logic [4:0] wdIndex = '0, rxIndex = '0;
  logic [7:0] wdData = '0, rxData, engTxByte, engRxByte = '0;
  logic [5:0] rxCount;
  logic busy, eomIrq, nackErr, pecErr, cntErr, alertIrq, engCmdValid, engAckOut;
  logic alertIn = 0, engDone = 0, engAckIn = 0;
  logic [2:0] engCmd;

  int errors = 0, checks = 0;
  int expQ[$];
  int rdQ[$];
  int writeNum = 0, nackAt = -1;
  logic [7:0] bufModel [32];
  logic [7:0] runCrc;

  smbus_pcall_master dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] crcB(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] r = c;
    for (int k = 7; k >= 0; k--) begin
      logic fb = r[7] ^ b[k];
      r = {r[6:0], 1'b0};
      if (fb) r = r ^ 8'h07;
    end
    return r;
  endfunction

  task automatic expEv(input int cmd, input int dat);
    expQ.push_back((cmd << 8) | dat);
  endtask

  task automatic expW(input logic [7:0] b);
    expEv(E_WRITE, b);
    runCrc = crcB(runCrc, b);
  endtask

  // Engine and slave model; monitor compares each primitive against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      engDone = 1'b0;
      if (engCmdValid) begin
        int ev, exp;
        ev = (int'(engCmd) << 8) |
             ((engCmd == 3'(E_WRITE)) ? int'(engTxByte) : (engCmd == 3'(E_ACK)) ? int'(engAckOut) : 0);
        if (expQ.size() == 0) chk("R13", "unexpected primitive", ev, -1);
        else begin
          exp = expQ.pop_front();
          chk("R13", "primitive sequence", ev, exp);
        end
        if (engCmd == 3'(E_WRITE)) begin
          engAckIn = (writeNum != nackAt);
          writeNum++;
        end
        if (engCmd == 3'(E_READ)) engRxByte = (rdQ.size() != 0) ? 8'(rdQ.pop_front()) : 8'hFF;
        @(negedge clk);
        @(negedge clk);
        engDone = 1'b1;
      end
    end
  end

  task automatic startCfg(input logic [6:0] a, input logic [7:0] cm, input int n,
                          input bit pc, input bit pec);
    @(negedge clk);
    cfgWrite = 1; cfgAddr = a; cfgCommand = cm; cfgCount = 6'(n);
    cfgProcCall = pc; cfgPecEn = pec;
    @(negedge clk);
    cfgWrite = 0;
  endtask

  task automatic waitEom(input string req);
    int k = 0;
    while (eomIrq !== 1'b1 && k < 4000) begin
      @(negedge clk);
      k++;
    end
    chk(req, "eomIrq seen (R10)", eomIrq, 1);
    chk("R10", "busy low with eomIrq", busy, 0);
    chk("R13", "all primitives issued", expQ.size(), 0);
    @(negedge clk);
    chk("R10", "eomIrq one cycle", eomIrq, 0);
  endtask

  task automatic rdChk(input string req, input int i, input logic [7:0] exp);
    rxIndex = 5'(i);
    #1;
    chk(req, "rxData", rxData, exp);
  endtask

  task automatic doPc(input logic [6:0] a, input logic [7:0] cm, input int n,
                      input int rc, input bit pec, input bit badPec, input bit load);
    bit bad = (rc == 0 || rc > 32);
    if (load) begin
      for (int i = 0; i < n; i++) begin
        @(negedge clk);
        bufModel[i] = 8'(i * 7 + 8'h21) ^ {1'b0, a};
        wdWrite = 1; wdIndex = 5'(i); wdData = bufModel[i];
      end
      @(negedge clk);
      wdWrite = 0;
    end
    writeNum = 0; nackAt = -1; runCrc = 8'h00;
    expEv(E_START, 0);
    expW({a, 1'b0}); expW(cm); expW(8'(n));
    for (int i = 0; i < n; i++) expW(bufModel[i]);
    expEv(E_RESTART, 0);
    expW({a, 1'b1});
    expEv(E_READ, 0);
    rdQ.push_back(rc);
    runCrc = crcB(runCrc, 8'(rc));
    if (bad) begin
      expEv(E_ACK, 0);
    end else begin
      expEv(E_ACK, 1);
      for (int i = 0; i < rc; i++) begin
        logic [7:0] d = 8'hA0 ^ 8'(i) ^ {1'b0, a};
        rdQ.push_back(d);
        runCrc = crcB(runCrc, d);
        expEv(E_READ, 0);
        expEv(E_ACK, (i == rc - 1 && !pec) ? 0 : 1);
      end
      if (pec) begin
        rdQ.push_back(runCrc ^ {7'd0, badPec});
        expEv(E_READ, 0);
        expEv(E_ACK, 0);
      end
    end
    expEv(E_STOP, 0);
    startCfg(a, cm, n, 1, pec);
    waitEom("R4");
    chk(bad ? "R9" : "R4", "rxCount", rxCount, bad ? 0 : rc);
    if (!bad) for (int i = 0; i < rc; i++) rdChk("R4", i, 8'hA0 ^ 8'(i) ^ {1'b0, a});
    chk("R6", "pecErr", pecErr, pec && badPec);
    chk("R9", "cntErr", cntErr, bad);
    chk("R8", "nackErr clear", nackErr, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // Reset state
    chk("R1", "busy after reset", busy, 0);
    chk("R10", "eomIrq after reset", eomIrq, 0);
    chk("R13", "engCmdValid after reset", engCmdValid, 0);
    chk("R8", "flags after reset", {nackErr, pecErr, cntErr}, 0);

    // R2 R3 R4 R5: plain process call
    doPc(7'h2A, 8'h5B, 2, 3, 0, 0, 1);
    // R6: good PEC then corrupted PEC
    doPc(7'h31, 8'hC4, 3, 2, 1, 0, 1);
    doPc(7'h31, 8'hC4, 1, 1, 1, 1, 1);
    // Boundaries: empty write, full 32-byte read
    doPc(7'h17, 8'h03, 0, 32, 0, 0, 1);
    // R9: count out of range
    doPc(7'h22, 8'h10, 1, 0, 0, 0, 1);
    doPc(7'h22, 8'h10, 1, 33, 1, 0, 1);

    // R7: alert response, PEC forced off
    rdQ.push_back(8'h5C);
    expEv(E_START, 0); expEv(E_WRITE, 8'h19); expEv(E_READ, 0); expEv(E_ACK, 0); expEv(E_STOP, 0);
    startCfg(7'h0C, 8'h00, 0, 0, 1);
    waitEom("R7");
    chk("R7", "alert rxCount", rxCount, 1);
    rdChk("R7", 0, 8'h5C);
    chk("R7", "alert no pecErr", pecErr, 0);

    // R8: slave NACKs the command byte
    writeNum = 0; nackAt = 1;
    expEv(E_START, 0); expEv(E_WRITE, {7'h2A, 1'b0}); expEv(E_WRITE, 8'h77); expEv(E_STOP, 0);
    startCfg(7'h2A, 8'h77, 2, 1, 0);
    waitEom("R8");
    chk("R8", "nackErr set", nackErr, 1);

    // R11: config and buffer writes while busy are ignored
    fork
      doPc(7'h40, 8'h99, 2, 1, 0, 0, 1);
      begin
        repeat (8) @(negedge clk);
        chk("R11", "busy during injection", busy, 1);
        cfgWrite = 1; cfgAddr = 7'h0C; wdWrite = 1; wdIndex = 0; wdData = 8'hEE;
        @(negedge clk);
        cfgWrite = 0; wdWrite = 0;
      end
    join
    doPc(7'h40, 8'h98, 2, 1, 0, 0, 0);
    chk("R11", "nackErr cleared by new start (R10)", nackErr, 0);

    // R1: no process-call bit and not alert address
    startCfg(7'h2A, 8'h01, 1, 0, 0);
    @(negedge clk);
    chk("R1", "no start without enable", busy, 0);
    repeat (5) @(negedge clk);
    chk("R1", "still idle", busy, 0);

    // R12: alert edge
    alertIn = 1;
    @(negedge clk);
    chk("R12", "alertIrq raised", alertIrq, 1);
    @(negedge clk);
    chk("R12", "alertIrq one cycle", alertIrq, 0);
    alertIn = 0;
    @(negedge clk);
    chk("R12", "no irq on fall", alertIrq, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog R13: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule